// File: doc/BRIEF.md
# Adaptive Test Clock Generator

This block produces a boundary-scan test clock from a fast base clock. A programmable divider sets the clock period. The divider takes a 4-bit mantissa, a 3-bit exponent and an optional extra divide-by-4 stage. Besides the clock, the block emits one-cycle strobes that mark each rising and each falling edge. The logic that shifts data on those edges uses the strobes as clock enables.

The block has two pacing modes. In fixed mode the clock runs at the divided rate whatever the target does. In adaptive mode the target's buffered copy of the clock comes back on a return input. Each new edge then waits until that return has followed the previous edge, so a slow or stalled target stretches the half-period it is in. The divider still sets the shortest half-period allowed in either mode.

When the run request drops, the current high phase is completed and the clock then parks low. Divider settings are taken only when a rising edge is launched. A whole period is therefore built from one setting, and a change can never produce a shortened pulse.

Top module: `tck_pacer`

## Requirements
- R1: After reset the clock output is low, both strobes are low, and no edge is produced while the run request is low.
- R2: With exponent 0 and the extra stage off, one period lasts mantissa + 4 base cycles.
- R3: With a nonzero exponent e and the extra stage off, one period lasts (mantissa + 1) * 2^(e+2) base cycles.
- R4: Enabling the extra stage multiplies the period of R2/R3 by 4.
- R5: For a period of D base cycles, the high half lasts floor(D/2) cycles and the low half lasts the rest, so an odd D gives a low half one cycle longer than the high half.
- R6: In adaptive mode, an edge is launched only when the return input, after a two-flop synchronizer, equals the present clock level. If the return is held still, the clock holds its level indefinitely. With the return equal to the clock delayed by k base cycles, no half lasts less than k + 3 cycles.
- R7: In adaptive mode, no half-period is shorter than the one set by the divider (R5).
- R8: The rise strobe is high for exactly the first cycle in which the clock is high. The fall strobe is high for exactly the first cycle in which the clock is low. At all other times both strobes are low.
- R9: A divider change made while the clock is running does not alter the period in progress. It applies from the next rising edge.
- R10: Dropping the run request during a high phase lets that high phase run to full length, and the clock then stays low. When run returns after the low half has expired, the clock rises on the next base cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Active-low reset |
| run_i | input | 1 | Run request; low parks the clock low |
| adapt_i | input | 1 | 1 = pace edges by the returned clock |
| div_mant_i | input | MANT_W | Divider mantissa |
| div_exp_i | input | EXP_W | Divider exponent |
| prediv_i | input | 1 | Enable the extra divide-by-4 stage |
| tckr_i | input | 1 | Returned clock from the target, asynchronous |
| tck_o | output | 1 | Generated test clock |
| tck_rise_o | output | 1 | One-cycle strobe marking a rising edge |
| tck_fall_o | output | 1 | One-cycle strobe marking a falling edge |

## Verification
The hardest case to reach from the ports is a returned clock that lags the output by a controlled number of cycles, or that stops moving in the middle of a phase. The bench builds the return from its own delay line fed by the output clock. The tap is selectable from zero to several cycles, and a hold switch freezes the return at a chosen level. This lets the stretched half-periods and the indefinite stall be measured against closed-form lengths. Divider changes are made in the middle of a high phase to show that the running period is unaffected.

// File: rtl/tckp_pkg.sv
package tckp_pkg;

  localparam int unsigned EXP0_OFFSET   = 4;
  localparam int unsigned PREDIV_FACTOR = 4;

  // Whole period in base cycles for a divider setting.
  function automatic int unsigned div_total(input int unsigned mant,
                                            input int unsigned expo,
                                            input logic        pre);
    int unsigned base;
    if (expo == 0) base = mant + EXP0_OFFSET;
    else           base = (mant + 1) << (expo + 2);
    return pre ? base * PREDIV_FACTOR : base;
  endfunction

  // High half takes the floor, low half takes the remainder.
  function automatic int unsigned half_high(input int unsigned div);
    return div >> 1;
  endfunction

  function automatic int unsigned half_low(input int unsigned div);
    return div - (div >> 1);
  endfunction

endpackage

// File: rtl/tckp_halves.sv
module tckp_halves #(
  parameter int MANT_W = 4,
  parameter int EXP_W  = 3,
  parameter int CNT_W  = 16
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              pre_i,
  output logic [CNT_W-1:0]  hi_len_o,
  output logic [CNT_W-1:0]  lo_len_o
);

  int unsigned div;

  always_comb begin
    div      = tckp_pkg::div_total(32'(mant_i), 32'(exp_i), pre_i);
    hi_len_o = CNT_W'(tckp_pkg::half_high(div));
    lo_len_o = CNT_W'(tckp_pkg::half_low(div));
  end

endmodule

// File: rtl/tckp_sync.sv
module tckp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= '0;
    else         chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/tckp_phase.sv
module tckp_phase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             adapt_i,
  input  logic             ret_i,
  input  logic [CNT_W-1:0] hi_len_i,
  input  logic [CNT_W-1:0] lo_len_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             half_done_o
);

  logic             tck_q, rise_q, fall_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lo_q;     // low length latched with the period
  logic             ret_ok, go_rise, go_fall;

  assign half_done_o = (cnt_q == '0);
  assign ret_ok      = !adapt_i || (ret_i == tck_q);
  assign go_fall     = tck_q  && half_done_o && ret_ok;
  assign go_rise     = !tck_q && half_done_o && ret_ok && run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tck_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      cnt_q  <= '0;
      lo_q   <= '0;
    end else begin
      rise_q <= go_rise;
      fall_q <= go_fall;
      if (go_rise) begin
        tck_q <= 1'b1;
        cnt_q <= hi_len_i - CNT_W'(1);
        lo_q  <= lo_len_i;
      end else if (go_fall) begin
        tck_q <= 1'b0;
        cnt_q <= lo_q - CNT_W'(1);
      end else if (!half_done_o) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign tck_o  = tck_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

endmodule

// File: rtl/tck_pacer.sv
module tck_pacer #(
  parameter int MANT_W      = 4,
  parameter int EXP_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              adapt_i,
  input  logic [MANT_W-1:0] div_mant_i,
  input  logic [EXP_W-1:0]  div_exp_i,
  input  logic              prediv_i,
  input  logic              tckr_i,
  output logic              tck_o,
  output logic              tck_rise_o,
  output logic              tck_fall_o
);

  // Largest period: 2^MANT_W * 2^(2^EXP_W - 1 + 2) * 4; one spare bit.
  localparam int CNT_W = MANT_W + (2**EXP_W - 1) + 2 + 2 + 1;

  logic [CNT_W-1:0] hi_len, lo_len;
  logic             ret_sync;
  logic             half_done;

  tckp_halves #(.MANT_W(MANT_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_halves (
    .mant_i   (div_mant_i),
    .exp_i    (div_exp_i),
    .pre_i    (prediv_i),
    .hi_len_o (hi_len),
    .lo_len_o (lo_len)
  );

  tckp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tckr_i),
    .q_o    (ret_sync)
  );

  tckp_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .adapt_i     (adapt_i),
    .ret_i       (ret_sync),
    .hi_len_i    (hi_len),
    .lo_len_i    (lo_len),
    .tck_o       (tck_o),
    .rise_o      (tck_rise_o),
    .fall_o      (tck_fall_o),
    .half_done_o (half_done)
  );

endmodule

// File: rtl/tck_pacer_chk.sv
module tck_pacer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic adapt_i,
  input logic tck_i,
  input logic rise_i,
  input logic fall_i,
  input logic ret_sync_i,
  input logic half_done_i
);

  a_r8_rise_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |-> (tck_i && !$past(tck_i)));

  a_r8_fall_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |-> (!tck_i && $past(tck_i)));

  a_r8_every_edge_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_i != $past(tck_i)) |-> (rise_i || fall_i));

  a_r6_fall_after_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && $past(adapt_i)) |-> $past(ret_sync_i));

  a_r6_rise_after_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && $past(adapt_i)) |-> !$past(ret_sync_i));

  a_r7_half_expired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i || fall_i) |-> $past(half_done_i));

  a_r10_parked_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !tck_i) |=> !tck_i);

endmodule

bind tck_pacer tck_pacer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .adapt_i     (adapt_i),
  .tck_i       (tck_o),
  .rise_i      (tck_rise_o),
  .fall_i      (tck_fall_o),
  .ret_sync_i  (ret_sync),
  .half_done_i (half_done)
);

// File: tb/tck_pacer_test.sv
module tck_pacer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       adapt = 1'b0;
  logic [3:0] mant = '0;
  logic [2:0] expo = '0;
  logic       pre = 1'b0;
  logic       tckr;
  logic       tck, rise, fall;

  logic [7:0] sr = '0;
  int         dly = 0;
  logic       hold = 1'b0;
  logic       held = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tck_pacer uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .run_i      (run),
    .adapt_i    (adapt),
    .div_mant_i (mant),
    .div_exp_i  (expo),
    .prediv_i   (pre),
    .tckr_i     (tckr),
    .tck_o      (tck),
    .tck_rise_o (rise),
    .tck_fall_o (fall)
  );

  // Return path: output clock delayed by dly base cycles, or frozen.
  always_ff @(posedge clk) sr <= {sr[6:0], tck};
  always_comb tckr = hold ? held : ((dly == 0) ? tck : sr[dly-1]);

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_period(input int m, input int e, input bit p);
    int d;
    d = (e == 0) ? (m + 4) : (m + 1) * 4 * (1 << e);
    if (p) d = d * 4;
    return d;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic wait_fall();
    @(negedge clk);
    while (!fall) @(negedge clk);
  endtask

  // Measures one period starting at the next observed rise strobe.
  task automatic measure(output int h, output int l, output int bad);
    while (!rise) @(negedge clk);
    h = 0; l = 0; bad = 0;
    while (tck) begin
      if (h == 0 ? !rise : (rise || fall)) bad++;
      h++;
      @(negedge clk);
    end
    while (!tck) begin
      if (l == 0 ? !fall : (rise || fall)) bad++;
      l++;
      @(negedge clk);
    end
  endtask

  task automatic sweep_one(input int m, input int e, input bit p);
    int h, l, b, d;
    string req;
    @(negedge clk);
    mant = 4'(m); expo = 3'(e); pre = p;
    wait_fall();
    measure(h, l, b);
    d   = ref_period(m, e, p);
    req = p ? "R4" : ((e == 0) ? "R2" : "R3");
    check_eq({req, " high"}, h, d / 2);
    check_eq({req, " low"},  l, d - d / 2);
    check_eq("R8 strobes", b, 0);
    if (d % 2 == 1) check_eq("R5 odd split", l - h, 1);
  endtask

  initial begin
    int h, l, b, cnt, seen;

    // R1: reset state and parked with run low
    repeat (3) @(negedge clk);
    check_eq("R1 tck in reset", int'(tck), 0);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tck || rise || fall) seen++;
    end
    check_eq("R1 idle after reset", seen, 0);

    // R2..R5, R8: fixed-mode sweep
    run = 1'b1;
    for (int e = 0; e < 3; e++)
      for (int m = 0; m < 16; m++)
        for (int p = 0; p < 2; p++)
          sweep_one(m, e, p[0]);
    for (int e = 3; e < 8; e++)
      for (int m = 0; m < 2; m++)
        sweep_one(m, e, 1'b0);

    // R6: adaptive with delayed return, divider at its shortest (2/2)
    @(negedge clk);
    adapt = 1'b1; mant = 4'd0; expo = 3'd0; pre = 1'b0;
    for (int d = 0; d < 6; d++) begin
      dly = d;
      wait_fall(); wait_fall();
      measure(h, l, b);
      check_eq("R6 adaptive high", h, imax(2, d + 3));
      check_eq("R6 adaptive low",  l, imax(2, d + 3));
    end

    // R7: divider dominates a short return delay
    mant = 4'd12; dly = 1;
    wait_fall(); wait_fall();
    measure(h, l, b);
    check_eq("R7 divider floor high", h, 8);
    check_eq("R7 divider floor low",  l, 8);
    mant = 4'd3; dly = 0;
    wait_fall(); wait_fall();
    measure(h, l, b);
    check_eq("R7 odd high", h, 3);
    check_eq("R7 odd low",  l, 4);

    // R6: frozen return stalls the clock high
    mant = 4'd0; dly = 1;
    wait_fall();
    while (!rise) @(negedge clk);
    held = 1'b0; hold = 1'b1;
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!tck || fall) seen++;
    end
    check_eq("R6 stall holds high", seen, 0);
    hold = 1'b0;
    cnt = 0;
    while (tck && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
    check_eq("R6 release latency", cnt, 3);

    // R9: mid-period change applies from the next rise
    @(negedge clk);
    adapt = 1'b0; mant = 4'd4; expo = 3'd0; pre = 1'b0;
    wait_fall();
    while (!rise) @(negedge clk);
    mant = 4'd8;
    h = 0; l = 0;
    while (tck)  begin h++; @(negedge clk); end
    while (!tck) begin l++; @(negedge clk); end
    check_eq("R9 current high kept", h, 4);
    check_eq("R9 current low kept",  l, 4);
    measure(h, l, b);
    check_eq("R9 next high", h, 6);
    check_eq("R9 next low",  l, 6);

    // R10: drop run in a high phase
    mant = 4'd4;
    wait_fall();
    while (!rise) @(negedge clk);
    run = 1'b0;
    h = 0;
    while (tck && h < 50) begin h++; @(negedge clk); end
    check_eq("R10 high completes", h, 4);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tck || rise) seen++;
    end
    check_eq("R10 parked low", seen, 0);
    run = 1'b1;
    @(negedge clk);
    check_eq("R10 restart tck", int'(tck), 1);
    check_eq("R10 restart strobe", int'(rise), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule